// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block forms the Montgomery product S = X·Y·2^-N mod M for N-bit operands. It handles the modulus and the multiplicand in W-bit words and the multiplier one bit at a time. A chain of P processing elements treats P neighbouring bits of X in one pass. Words of Y and M enter the first element and move two register stages further at each element. The running sum S also moves down the chain. Only the final element writes S words back into a local result store, and the first element reads that store on the next pass.

The operands are sampled from the operand ports when a start pulse is accepted. They are then held in word storage inside the block, and the ports are not read again until the next accepted start. After the last result word has been written, `done` pulses for one cycle. `res` shows the whole result store at all times. The value is below 2M and is not reduced any further. The user must supply an odd M with X < M and Y < M. N must be a multiple of both W and P, and W must be at least 2.

Top module: `wsmont_mul`

## Requirements
- R1: During reset and immediately after it, `done` is 0 and `res` is 0.
- R2: After a run, `res` equals the value given by N bit-serial steps, starting from S = 0 and taking bits of X from LSB upward: S += x_i·Y; if S is odd, S += M; S = S/2.
- R3: The result satisfies (res·2^N) mod M = (X·Y) mod M, and res < 2M.
- R4: Let E = N/W and T = max(2P+1, E+2). `done` goes high on the rising edge that comes (N/P−1)·T + 2P + E + 1 edges after the edge that samples an accepted start.
- R5: `done` is a one-cycle pulse, and it occurs exactly once for each accepted start.
- R6: A start that arrives while a run is in progress is ignored. The result and the done timing of the current run do not change, and operand port changes after acceptance have no effect.
- R7: A start presented in the cycle in which `done` is high is accepted.
- R8: The first element's sweep presents the same group of P bits of X on every word after word 0. Element k of pass r uses bit r·P+k.
- R9: Each element begins its sweep exactly two cycles after its predecessor. Its Y and M words stay aligned with the S word of the same index.
- R10: When an element closes a sweep, both of its carries out of the top word are zero, so the word above the top word receives only the shifted-in zero.
- R11: The last element writes result words in ascending index order on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; honoured only while idle |
| op_x | input | N | Multiplier X, sampled at accepted start |
| op_y | input | N | Multiplicand Y, sampled at accepted start |
| op_m | input | N | Odd modulus M, sampled at accepted start |
| done | output | 1 | One-cycle pulse after the final result word is written |
| res | output | N+1 | Result store contents, S < 2M |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle. The final word is written, `done` rises, and a new `start` is sampled on the edge that closes that cycle. The bench provokes this by driving the next start in the cycle where `done` is seen high, for several back-to-back random products. Each of those runs is judged by its exact result and by its latency measured from the edge that accepted it. A second clash is a start, together with changed operand ports, driven in the middle of a run. It is judged by an unchanged result and latency and by the absence of any extra `done`.

// File: rtl/wsmont_pkg.sv
package wsmont_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_DRAIN
  } seq_state_e;

  // Cycles between consecutive passes at the head of the chain: the head
  // element needs its sweep plus a flush slot, and the tail element must
  // have written word k before the head reads it again.
  function automatic int pass_period(input int words, input int pes);
    return (2 * pes + 1 > words + 2) ? 2 * pes + 1 : words + 2;
  endfunction

endpackage

// File: rtl/wsmont_pe.sv
module wsmont_pe #(
  parameter int W  = 8,
  parameter int JW = 4,
  parameter int E  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [JW-1:0] in_j,
  input  logic          in_last,
  input  logic [W-1:0]  in_y,
  input  logic [W-1:0]  in_m,
  input  logic [W-1:0]  in_s,
  input  logic          in_xb,
  output logic          s_v,
  output logic [JW-1:0] s_idx,
  output logic          s_last,
  output logic [W-1:0]  s_word,
  output logic [W-1:0]  dn_y,
  output logic [W-1:0]  dn_m
);

  localparam logic [JW-1:0] TOPJ = JW'(E);

  logic          first;
  logic          xb_eff, qsel;
  logic [W:0]    a_sum, b_sum;
  logic          xq, qq, ca, cb;
  logic [W-1:0]  uprev;
  logic          flush, flush_last;
  logic [W-1:0]  y1, m1;

  assign first  = (in_j == '0);
  assign xb_eff = first ? in_xb : xq;

  always_comb begin
    a_sum = {1'b0, in_s} + (xb_eff ? {1'b0, in_y} : '0)
          + {{W{1'b0}}, ca & ~first};
    qsel  = first ? a_sum[0] : qq;
    b_sum = {1'b0, a_sum[W-1:0]} + (qsel ? {1'b0, in_m} : '0)
          + {{W{1'b0}}, cb & ~first};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y1 <= '0; m1 <= '0; dn_y <= '0; dn_m <= '0;
      xq <= 1'b0; qq <= 1'b0; ca <= 1'b0; cb <= 1'b0; uprev <= '0;
      flush <= 1'b0; flush_last <= 1'b0;
      s_v <= 1'b0; s_idx <= '0; s_last <= 1'b0; s_word <= '0;
    end else begin
      y1   <= in_y;
      m1   <= in_m;
      dn_y <= y1;
      dn_m <= m1;
      flush      <= in_v && (in_j == TOPJ);
      flush_last <= in_last;
      if (in_v) begin
        xq    <= xb_eff;
        qq    <= qsel;
        ca    <= a_sum[W];
        cb    <= b_sum[W];
        uprev <= b_sum[W-1:0];
      end
      if (flush) begin
        s_v    <= 1'b1;
        s_idx  <= TOPJ;
        s_last <= flush_last;
        s_word <= {1'b0, uprev[W-1:1]};
      end else begin
        s_v    <= in_v && !first;
        s_idx  <= in_j - JW'(1);
        s_last <= in_last;
        s_word <= {b_sum[0], uprev[W-1:1]};
      end
    end
  end

  // R10: nothing carries out of the top word when the sweep closes
  a_r10_top_word_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ca == 1'b0 && cb == 1'b0));

  // R9: output sweep begins two cycles after the input sweep
  a_r9_two_stage_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_v) |-> ##2 $rose(s_v));

endmodule

// File: rtl/wsmont_seq.sv
module wsmont_seq
  import wsmont_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 8,
  parameter int P = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [N-1:0]                op_x,
  input  logic                        fin,
  output logic                        load,
  output logic                        f_v,
  output logic [$clog2(N/W+1)-1:0]    f_j,
  output logic                        f_last,
  output logic [P-1:0]                xbits,
  output logic                        done
);

  localparam int E  = N / W;
  localparam int NP = N / P;
  localparam int T  = pass_period(E, P);
  localparam int CW = $clog2(T);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam int JW = $clog2(E + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pass;
  logic [N-1:0]  xsh;

  assign load   = (state == SEQ_IDLE) && start;
  assign f_v    = (state == SEQ_RUN) && (cnt <= CW'(E));
  assign f_j    = f_v ? cnt[JW-1:0] : '0;
  assign f_last = (pass == PW'(NP - 1));
  assign xbits  = xsh[P-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      pass  <= '0;
      xsh   <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_RUN;
            cnt   <= '0;
            pass  <= '0;
            xsh   <= op_x;
          end
        end
        SEQ_RUN: begin
          if (cnt == CW'(T - 1)) begin
            cnt  <= '0;
            pass <= pass + PW'(1);
            xsh  <= xsh >> P;
          end else begin
            cnt <= cnt + CW'(1);
          end
          if (f_last && cnt == CW'(E)) state <= SEQ_DRAIN;
        end
        default: begin
          if (fin) state <= SEQ_IDLE;
        end
      endcase
    end
  end

  // R8: bit group stays put for the whole head sweep
  a_r8_xbits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (f_v && f_j != '0) |-> $stable(xbits));

  // R6: a start during a run never returns the sequencer to idle
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN && start) |=> (state != SEQ_IDLE));

endmodule

// File: rtl/wsmont_mul.sv
module wsmont_mul #(
  parameter int N = 64,
  parameter int W = 8,
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_x,
  input  logic [N-1:0] op_y,
  input  logic [N-1:0] op_m,
  output logic         done,
  output logic [N:0]   res
);

  localparam int E     = N / W;
  localparam int JW    = $clog2(E + 1);
  localparam int DEPTH = 2 ** JW;
  localparam int PADW  = DEPTH * W - N;

  logic                 load, f_v, f_last, fin;
  logic [JW-1:0]        f_j;
  logic [P-1:0]         xbits;

  logic [DEPTH*W-1:0]   y_all, m_all;
  logic [N-1:0]         s_all;
  logic                 s_top;

  logic [P:0]           c_v, c_last;
  logic [JW-1:0]        c_j [P+1];
  logic [W-1:0]         c_y [P+1];
  logic [W-1:0]         c_m [P+1];
  logic [W-1:0]         c_s [P+1];

  wsmont_seq #(.N(N), .W(W), .P(P)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_x(op_x), .fin(fin),
    .load(load), .f_v(f_v), .f_j(f_j), .f_last(f_last), .xbits(xbits),
    .done(done)
  );

  // head of chain: sequencer slot plus word reads from local storage
  assign c_v[0]    = f_v;
  assign c_j[0]    = f_j;
  assign c_last[0] = f_last;
  assign c_y[0]    = y_all[f_j*W +: W];
  assign c_m[0]    = m_all[f_j*W +: W];
  assign c_s[0]    = (f_j == JW'(E)) ? {{(W-1){1'b0}}, s_top} : s_all[f_j*W +: W];

  for (genvar k = 0; k < P; k++) begin : g_pe
    wsmont_pe #(.W(W), .JW(JW), .E(E)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .in_v(c_v[k]), .in_j(c_j[k]), .in_last(c_last[k]),
      .in_y(c_y[k]), .in_m(c_m[k]), .in_s(c_s[k]), .in_xb(xbits[k]),
      .s_v(c_v[k+1]), .s_idx(c_j[k+1]), .s_last(c_last[k+1]),
      .s_word(c_s[k+1]), .dn_y(c_y[k+1]), .dn_m(c_m[k+1])
    );
  end

  assign fin = c_v[P] && (c_j[P] == JW'(E)) && c_last[P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_all <= '0;
      m_all <= '0;
      s_all <= '0;
      s_top <= 1'b0;
    end else if (load) begin
      y_all <= {{PADW{1'b0}}, op_y};
      m_all <= {{PADW{1'b0}}, op_m};
      s_all <= '0;
      s_top <= 1'b0;
    end else if (c_v[P]) begin
      if (c_j[P] == JW'(E)) s_top <= c_s[P][0];
      else                  s_all[c_j[P]*W +: W] <= c_s[P];
    end
  end

  assign res = {s_top, s_all};

  // R11: tail writes climb one index per cycle
  a_r11_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v[P] && c_j[P] != '0) |-> ($past(c_v[P]) && $past(c_j[P]) == c_j[P] - JW'(1)));

  // R9: Y and M words leave the chain aligned with the S word index
  a_r9_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    c_v[P] |-> (c_y[P] == y_all[c_j[P]*W +: W] && c_m[P] == m_all[c_j[P]*W +: W]));

  // R5: done lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_wsmont_mul.sv
`timescale 1ns/1ps
module test_wsmont_mul;
  import wsmont_pkg::*;

  localparam int N = 64;
  localparam int W = 8;
  localparam int P = 4;
  localparam int E = N / W;
  localparam int T = pass_period(E, P);
  localparam int L = (N / P - 1) * T + 2 * P + E + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] op_x = '0, op_y = '0, op_m = '0;
  logic         done;
  logic [N:0]   res;

  wsmont_mul #(.N(N), .W(W), .P(P)) i_wsmont_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_x(op_x), .op_y(op_y), .op_m(op_m), .done(done), .res(res)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  typedef struct {
    logic [N:0]   s;
    logic [N-1:0] x, y, m;
    int           t0;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [N:0] act, input logic [N:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N:0] ref_mont(input logic [N-1:0] x, y, m);
    logic [N+1:0] s = '0;
    for (int i = 0; i < N; i++) begin
      if (x[i]) s = s + {2'b00, y};
      if (s[0]) s = s + {2'b00, m};
      s = s >> 1;
    end
    return s[N:0];
  endfunction

  // driver: entered at a falling edge, returns at the falling edge of the done cycle
  task automatic run(input logic [N-1:0] x, y, m, input bit poke);
    exp_t e;
    op_x = x; op_y = y; op_m = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e.s = ref_mont(x, y, m); e.x = x; e.y = y; e.m = m; e.t0 = cyc;
    sb.push_back(e);
    if (poke) begin
      repeat (20) @(negedge clk);
      op_x = ~x; op_y = ~y; op_m = 64'h3;
      start = 1'b1;                         // R6: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  // monitor / scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin : mon
    exp_t e;
    logic [2*N+1:0] lhs, rhs, mw;
    if (rst_n) begin
      if (prev_done) chk(!done, "R5 done pulse width", {{N{1'b0}}, done}, '0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R5 done without accepted start", {{N{1'b0}}, done}, '0);
        end else begin
          e = sb.pop_front();
          chk(res == e.s, "R2 R8 R9 R10 R11 result value", res, e.s);
          mw  = {{(N+2){1'b0}}, e.m};
          lhs = ({{(N+1){1'b0}}, res} << N) % mw;
          rhs = ({{(N+2){1'b0}}, e.x} * {{(N+2){1'b0}}, e.y}) % mw;
          chk(lhs == rhs, "R3 congruence", lhs[N:0], rhs[N:0]);
          chk(res < {e.m, 1'b0}, "R3 below 2M", res, {e.m, 1'b0});
          chk((cyc - e.t0) == L - 1, "R4 R6 R7 latency",
              (N+1)'(cyc - e.t0), (N+1)'(L - 1));
        end
      end
      prev_done <= done;
    end
  end

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    finish_up();
  end

  initial begin : main
    logic [N-1:0] m, x, y;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", {{N{1'b0}}, done}, '0);
    chk(res == '0, "R1 reset res", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && res == '0, "R1 after reset", res, '0);

    run(64'd3, 64'd5, 64'd17, 0);
    run(64'd0, 64'd16, 64'd17, 0);                          // R7 back to back
    run(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE,
        64'hFFFF_FFFF_FFFF_FFFF, 0);
    run(64'd0, 64'd0, 64'd1, 0);
    for (int k = 0; k < 5; k++) begin
      m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
      x = {$urandom, $urandom} % m;
      y = {$urandom, $urandom} % m;
      run(x, y, m, 0);
    end
    m = {$urandom, $urandom} | 64'h1;
    x = {$urandom, $urandom} % m;
    y = {$urandom, $urandom} % m;
    run(x, y, m, 1);                                        // R6 mid-run start
    repeat (L + 10) @(negedge clk);
    chk(sb.size() == 0 && !done, "R5 R6 no stray run",
        (N+1)'(sb.size()), '0);
    finish_up();
  end

endmodule